// File: doc/BRIEF.md
# Waveform Timer/Counter

An 8-bit timer/counter that advances on a count-enable tick and drives one waveform output. It has four operating modes, chosen by two mode bits: a free-running up counter, a counter that clears when it equals the compare value, a single-slope PWM that counts up and wraps, and a dual-slope PWM that counts up to 0xFF and back down to 0x00. A compare register is matched against the count. The match drives the output through a selectable output action, and it sets a compare flag. An overflow flag marks the mode's end-of-period point.

Software reaches the block through a small write/read register port. The port holds a control register (mode, output action, force strobe), a read-only count, the compare register and a flag register whose flags are cleared by writing 1. In the two PWM modes, compare writes go to a shadow copy that is applied at a mode-dependent point, so a period never sees a torn duty value. The output enable is raised only when an output action is selected and the external direction bit allows the driver.

Top module: `wgt_timer`

## Requirements
- R1: After reset the count is 0, the output and output enable are low, both flags are 0, and the control register reads 0.
- R2: The count changes only on cycles with `tick` high. In mode 00 it counts up and wraps from 0xFF to 0x00, and the overflow flag (flag register bit 0) is set by the tick taken at 0xFF.
- R3: In mode 10 the tick taken while the count equals the active compare value loads 0. No overflow flag is set unless the count reaches 0xFF.
- R4: In mode 01 the count runs 0,1,…,0xFF,0xFE,…,0,1,…. The overflow flag is set only by the tick that leaves 0x00 while counting down, and not at the turn at 0xFF.
- R5: The compare flag (flag register bit 1) is set by a tick taken while the count equals the active compare value. Writing 1 to a flag bit at address 3 clears it. A set and a clear in the same cycle leave the flag set.
- R6: Address 2 reads back the last written compare value. In modes 00/10 that value becomes active on the next cycle. In mode 11 it becomes active on the tick at 0xFF. In mode 01 it becomes active on the tick at the 0xFF turn.
- R7: In modes 00/10 a match applies the output action (control bits [3:2]): 01 toggles the output, 10 drives it low, 11 drives it high, and 00 leaves it unchanged.
- R8: In mode 11 with action 10, the tick at 0xFF drives the output high and a match drives it low. Action 11 does the opposite.
- R9: In mode 01 with action 10, a match while counting up drives the output low and a match while counting down drives it high. Action 11 does the opposite.
- R10: Writing control bit 7 = 1 in mode 00/10 applies the written output action at once. It sets no flag and does not clear the count. Bit 7 always reads 0. The strobe is ignored when the written mode is 01 or 11. If it coincides with a match, only the forced action reaches the output, and the match still sets its flag and still clears the count in mode 10.
- R11: `wave_oe` is high exactly when the output action is nonzero and `dir_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count, 2 compare, 3 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| dir_en | input | 1 | Direction bit of the pin; allows the driver |
| wave_out | output | 1 | Waveform output |
| wave_oe | output | 1 | Output override valid |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
A forced compare and a real compare match can land on the same clock edge. Both then try to change the one output register, and the match also wants to set its flag and clear the count. The bench brings this about by parking the counter on the compare value in clear-on-match toggle mode, then raising `tick` in the same cycle as a control write that carries the strobe. It judges the result by a single toggle on the output, the compare flag set and the count back at zero. The same pile-up happens on the flag register, where a match tick meets a write-one-to-clear in one cycle, and there the set must win.

// File: rtl/wgt_pkg.sv
// Package for the waveform timer.
// Holds the mode and output-action encodings and the register addresses.
// Assumes a register data width of at least 8 bits (strobe sits in bit 7).
package wgt_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_DUAL  = 2'b01,
        MODE_CLR   = 2'b10,
        MODE_FAST  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } tact_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_CMP   = 2'd2;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;
    localparam int         FORCE_BIT  = 7;

    // Modes 01 and 11 are the PWM modes: bit 0 of the mode selects them.
    function automatic logic is_pwm(tmode_e m);
        return m[0];
    endfunction
endpackage

// File: rtl/wgt_count.sv
// Counter core of the waveform timer.
// Steps once per tick in the sequence picked by the mode and reports the
// per-tick events (wrap at MAX, dual-slope bottom, compare match).
// Assumes cmp_act is stable for the cycle; events are combinational and
// qualified by tick.
module wgt_count
    import wgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmode_e       mode,
    input  logic [W-1:0] cmp_act,
    output logic [W-1:0] cnt,
    output logic         cnt_dn,
    output logic         ev_max,
    output logic         ev_dual_bot,
    output logic         ev_match
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic at_max;
    logic at_zero;

    // Decode the count landmarks and the tick events.
    always_comb begin
        at_max      = (cnt == CNT_MAX);
        at_zero     = (cnt == '0);
        ev_max      = tick && at_max && (mode != MODE_DUAL || !cnt_dn);
        ev_dual_bot = tick && (mode == MODE_DUAL) && cnt_dn && at_zero;
        ev_match    = tick && (cnt == cmp_act);
    end

    // Advance the count and the slope direction on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            cnt_dn <= 1'b0;
        end else if (tick) begin
            unique case (mode)
                MODE_DUAL: begin
                    if (!cnt_dn) begin
                        if (at_max) begin
                            cnt    <= CNT_MAX - CNT_ONE;
                            cnt_dn <= 1'b1;
                        end else begin
                            cnt <= cnt + CNT_ONE;
                        end
                    end else if (at_zero) begin
                        cnt    <= CNT_ONE;
                        cnt_dn <= 1'b0;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                MODE_CLR: begin
                    cnt    <= (cnt == cmp_act) ? '0 : cnt + CNT_ONE;
                    cnt_dn <= 1'b0;
                end
                default: begin
                    cnt    <= cnt + CNT_ONE;
                    cnt_dn <= 1'b0;
                end
            endcase
        end
    end

    // R2: without a tick the count holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R3: a match tick in clear-on-match mode returns the count to zero.
    p_ctc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_CLR && cnt == cmp_act) |=> (cnt == '0));

    // R4: dual-slope mode moves by exactly one per tick.
    p_dual_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_DUAL) |=>
            (cnt == $past(cnt) + CNT_ONE || cnt == $past(cnt) - CNT_ONE));
endmodule

// File: rtl/wgt_cmpreg.sv
// Compare register with a shadow copy.
// The written value is held in cmp_buf; cmp_act is what the counter matches.
// Outside the PWM modes cmp_act follows cmp_buf every cycle; in PWM modes it
// is loaded only on the update event supplied by the counter.
module wgt_cmpreg
    import wgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  tmode_e       mode,
    input  logic         upd,
    output logic [W-1:0] cmp_buf,
    output logic [W-1:0] cmp_act
);
    logic pwm;

    // Classify the mode for the buffering rule.
    always_comb pwm = is_pwm(mode);

    // Capture software writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n)  cmp_buf <= '0;
        else if (wr) cmp_buf <= wdata;
    end

    // Move the shadow copy into the active value at the mode's update point.
    always_ff @(posedge clk) begin
        if (!rst_n)           cmp_act <= '0;
        else if (!pwm || upd) cmp_act <= cmp_buf;
    end

    // R6: in PWM modes the active compare value changes only at the update point.
    p_buffer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !upd) |=> $stable(cmp_act));
endmodule

// File: rtl/wgt_wave.sv
// Waveform output register.
// Applies the forced action, the PWM set/clear points or the non-PWM match
// action to one output bit. A forced action takes the place of a match action
// in the same cycle. Assumes events arrive already qualified by tick.
module wgt_wave
    import wgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  tmode_e mode,
    input  tact_e  act,
    input  logic   cnt_dn,
    input  logic   ev_max,
    input  logic   ev_match,
    input  logic   force_go,
    input  tact_e  force_act,
    output logic   wave
);
    logic wave_nxt;

    // Result of a non-PWM action on the current output.
    function automatic logic apply_act(tact_e a, logic cur);
        unique case (a)
            ACT_TOGGLE: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

    // Pick the next output level by priority: force, PWM points, match.
    always_comb begin
        wave_nxt = wave;
        if (force_go) begin
            wave_nxt = apply_act(force_act, wave);
        end else if (mode == MODE_FAST) begin
            if (act == ACT_LOW || act == ACT_HIGH) begin
                if (ev_max)        wave_nxt = (act == ACT_LOW);
                else if (ev_match) wave_nxt = (act == ACT_HIGH);
            end
        end else if (mode == MODE_DUAL) begin
            if (ev_match && (act == ACT_LOW || act == ACT_HIGH))
                wave_nxt = (act == ACT_LOW) ? cnt_dn : !cnt_dn;
        end else if (ev_match) begin
            wave_nxt = apply_act(act, wave);
        end
    end

    // Hold the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= wave_nxt;
    end

    // R8: in fast PWM with action 10 the wrap tick leaves the output high.
    p_fast_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_go && mode == MODE_FAST && act == ACT_LOW && ev_max) |=> wave);
endmodule

// File: rtl/wgt_timer.sv
// Waveform timer/counter top level.
// Holds the control and flag registers, decodes the register port and ties
// the counter, compare register and output logic together. The force strobe
// is taken from write data and never stored. Assumes W >= 8.
module wgt_timer
    import wgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         dir_en,
    output logic         wave_out,
    output logic         wave_oe,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    localparam int PAD_CTRL = W - 4;
    localparam int PAD_FLAG = W - 2;

    tmode_e       mode_q;
    tact_e        act_q;
    logic         wr_ctrl;
    logic         wr_cmp;
    logic         wr_flags;
    logic         force_go;
    tmode_e       wr_mode;
    tact_e        wr_act;
    logic [W-1:0] cnt;
    logic         cnt_dn;
    logic         ev_max;
    logic         ev_dual_bot;
    logic         ev_match;
    logic [W-1:0] cmp_buf;
    logic [W-1:0] cmp_act;
    logic         ovf_set;

    // Decode register writes and the force strobe.
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
        wr_cmp   = reg_wr && (reg_addr == ADDR_CMP);
        wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);
        wr_mode  = tmode_e'(reg_wdata[1:0]);
        wr_act   = tact_e'(reg_wdata[3:2]);
        force_go = wr_ctrl && reg_wdata[FORCE_BIT] && !is_pwm(wr_mode);
    end

    // Store mode and output action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PLAIN;
            act_q  <= ACT_NONE;
        end else if (wr_ctrl) begin
            mode_q <= wr_mode;
            act_q  <= wr_act;
        end
    end

    wgt_count #(.W(W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode       (mode_q),
        .cmp_act    (cmp_act),
        .cnt        (cnt),
        .cnt_dn     (cnt_dn),
        .ev_max     (ev_max),
        .ev_dual_bot(ev_dual_bot),
        .ev_match   (ev_match)
    );

    wgt_cmpreg #(.W(W)) u_cmpreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_cmp),
        .wdata  (reg_wdata),
        .mode   (mode_q),
        .upd    (ev_max),
        .cmp_buf(cmp_buf),
        .cmp_act(cmp_act)
    );

    wgt_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .act      (act_q),
        .cnt_dn   (cnt_dn),
        .ev_max   (ev_max),
        .ev_match (ev_match),
        .force_go (force_go),
        .force_act(wr_act),
        .wave     (wave_out)
    );

    // Select the overflow point for the current mode.
    always_comb ovf_set = (mode_q == MODE_DUAL) ? ev_dual_bot : ev_max;

    // Set flags on events; write-one clears, and a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_set  || (ovf_flag && !(wr_flags && reg_wdata[0]));
            cmp_flag <= ev_match || (cmp_flag && !(wr_flags && reg_wdata[1]));
        end
    end

    // Read mux and pin override.
    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, act_q, mode_q};
            ADDR_COUNT: reg_rdata = cnt;
            ADDR_CMP:   reg_rdata = cmp_buf;
            default:    reg_rdata = {{PAD_FLAG{1'b0}}, cmp_flag, ovf_flag};
        endcase
        wave_oe = (act_q != ACT_NONE) && dir_en;
    end

    // R10: a strobe without a match never sets the compare flag.
    p_force_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_go && !ev_match && !cmp_flag) |=> !cmp_flag);

    // R4: in dual-slope mode the overflow flag stays clear away from the bottom.
    p_dual_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL && !ev_dual_bot && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/sim_wgt_timer.sv
`timescale 1ns/1ps
// Directed bench for wgt_timer: one task per scenario, each checking itself.
module sim_wgt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       dir_en = 1'b0;
    logic       wave_out;
    logic       wave_oe;
    logic       ovf_flag;
    logic       cmp_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    wgt_timer #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dir_en(dir_en), .wave_out(wave_out), .wave_oe(wave_oe),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0; dir_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 count", v, 8'h00);
        check("R1 wave", {7'd0, wave_out}, 8'd0);
        check("R1 oe", {7'd0, wave_oe}, 8'd0);
        check("R1 flags", {6'd0, cmp_flag, ovf_flag}, 8'd0);
    endtask

    task automatic t_plain();
        logic [7:0] v;
        do_reset();
        repeat (5) @(negedge clk);
        rd(2'd1, v); check("R2 no tick hold", v, 8'd0);
        ticks(10);  rd(2'd1, v); check("R2 count 10", v, 8'd10);
        ticks(245); rd(2'd1, v); check("R2 count 255", v, 8'd255);
        check("R2 ovf before wrap", {7'd0, ovf_flag}, 8'd0);
        ticks(1);   rd(2'd1, v); check("R2 wrap to 0", v, 8'd0);
        check("R2 ovf at wrap", {7'd0, ovf_flag}, 8'd1);
        wr(2'd3, 8'h01);
        check("R5 ovf cleared", {7'd0, ovf_flag}, 8'd0);
    endtask

    task automatic t_ctc();
        logic [7:0] v;
        do_reset();
        dir_en = 1'b1;
        wr(2'd2, 8'd9);
        wr(2'd0, 8'h06);
        ticks(9); rd(2'd1, v); check("R3 count 9", v, 8'd9);
        check("R5 no match yet", {7'd0, cmp_flag}, 8'd0);
        ticks(1); rd(2'd1, v); check("R3 clear at match", v, 8'd0);
        check("R5 match flag", {7'd0, cmp_flag}, 8'd1);
        check("R7 toggle high", {7'd0, wave_out}, 8'd1);
        ticks(10); check("R7 toggle low", {7'd0, wave_out}, 8'd0);
        check("R3 no ovf", {7'd0, ovf_flag}, 8'd0);
        wr(2'd3, 8'h02);
        check("R5 match cleared", {7'd0, cmp_flag}, 8'd0);
        wr(2'd0, 8'h0E); ticks(10);
        check("R7 set on match", {7'd0, wave_out}, 8'd1);
        wr(2'd0, 8'h0A); ticks(10);
        check("R7 clear on match", {7'd0, wave_out}, 8'd0);
        ticks(9);
        @(negedge clk);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h02;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        check("R5 set beats clear", {7'd0, cmp_flag}, 8'd1);
    endtask

    task automatic t_fast();
        logic [7:0] v;
        do_reset();
        wr(2'd2, 8'd100);
        wr(2'd0, 8'h0B);
        ticks(100); check("R8 low before wrap", {7'd0, wave_out}, 8'd0);
        ticks(1);   check("R8 low after match", {7'd0, wave_out}, 8'd0);
        ticks(155); rd(2'd1, v); check("R8 wrapped", v, 8'd0);
        check("R8 high at bottom", {7'd0, wave_out}, 8'd1);
        check("R2 fast ovf", {7'd0, ovf_flag}, 8'd1);
        ticks(10);
        wr(2'd2, 8'd20);
        rd(2'd2, v); check("R6 readback", v, 8'd20);
        ticks(10); ticks(1);
        check("R6 buffered, no early match", {7'd0, wave_out}, 8'd1);
        ticks(79); ticks(1);
        check("R8 clear at old compare", {7'd0, wave_out}, 8'd0);
        ticks(155); check("R8 high again", {7'd0, wave_out}, 8'd1);
        ticks(20); ticks(1);
        check("R6 new compare at bottom", {7'd0, wave_out}, 8'd0);
    endtask

    task automatic t_dual();
        logic [7:0] v;
        do_reset();
        wr(2'd2, 8'd100);
        wr(2'd0, 8'h09);
        ticks(101); rd(2'd1, v); check("R4 up to 101", v, 8'd101);
        check("R9 low after up match", {7'd0, wave_out}, 8'd0);
        wr(2'd3, 8'h03);
        wr(2'd2, 8'd150);
        ticks(50);
        check("R6 dual buffered", {7'd0, cmp_flag}, 8'd0);
        ticks(104); rd(2'd1, v); check("R4 at top", v, 8'd255);
        ticks(1);   rd(2'd1, v); check("R4 turn down", v, 8'd254);
        check("R4 no ovf at top", {7'd0, ovf_flag}, 8'd0);
        ticks(104); ticks(1);
        rd(2'd1, v); check("R4 down count", v, 8'd149);
        check("R9 high on down match", {7'd0, wave_out}, 8'd1);
        check("R6 new compare after top", {7'd0, cmp_flag}, 8'd1);
        ticks(149); rd(2'd1, v); check("R4 bottom", v, 8'd0);
        check("R4 no ovf before leave", {7'd0, ovf_flag}, 8'd0);
        ticks(1); rd(2'd1, v); check("R4 turn up", v, 8'd1);
        check("R4 ovf at bottom", {7'd0, ovf_flag}, 8'd1);
        ticks(150);
        check("R9 low on up match", {7'd0, wave_out}, 8'd0);
    endtask

    task automatic t_force();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h84);
        check("R10 forced toggle", {7'd0, wave_out}, 8'd1);
        rd(2'd0, v); check("R10 strobe reads 0", v, 8'h04);
        check("R10 no flag", {7'd0, cmp_flag}, 8'd0);
        wr(2'd2, 8'd20);
        wr(2'd0, 8'h06);
        ticks(5);
        wr(2'd0, 8'h86);
        check("R10 forced toggle in clear mode", {7'd0, wave_out}, 8'd0);
        rd(2'd1, v); check("R10 no counter clear", v, 8'd5);
        check("R10 no flag in clear mode", {7'd0, cmp_flag}, 8'd0);
        wr(2'd0, 8'h8F);
        check("R10 ignored in PWM", {7'd0, wave_out}, 8'd0);
        do_reset();
        wr(2'd2, 8'd3);
        wr(2'd0, 8'h06);
        ticks(3);
        @(negedge clk);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h86;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        check("R10 single toggle on collision", {7'd0, wave_out}, 8'd1);
        rd(2'd1, v); check("R10 match still clears", v, 8'd0);
        check("R10 match still flags", {7'd0, cmp_flag}, 8'd1);
    endtask

    task automatic t_override();
        do_reset();
        dir_en = 1'b0;
        wr(2'd0, 8'h04);
        check("R11 oe off without dir", {7'd0, wave_oe}, 8'd0);
        dir_en = 1'b1; #0.5;
        check("R11 oe on", {7'd0, wave_oe}, 8'd1);
        wr(2'd0, 8'h00);
        check("R11 oe off when disconnected", {7'd0, wave_oe}, 8'd0);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_plain();
        t_ctc();
        t_fast();
        t_dual();
        t_force();
        t_override();
        finish_up();
    end
endmodule